// File: doc/BRIEF.md
# Indirect Video Memory Access Window with Row Scroll

This block sits between an 8-bit processor bus and a private video memory that the processor cannot address directly. Software picks a byte in video memory by loading a 16-bit pointer through two byte registers. It then reads or writes a single data port, and that access reaches the byte the pointer selects. When stepping is switched on, every accepted data-port access moves the pointer forward by one. A program can then stream a run of bytes without reloading the pointer. Reads are served from a prefetched copy of the addressed byte, and that copy is refreshed whenever the pointer moves.

The block also holds a text screen of 80 columns by 25 rows. Each cell takes two bytes: the character code at the even offset and its colour attribute at the odd offset. A single command shifts the whole screen up by one line in hardware, with no copying by the processor. The top line is lost, and the bottom line is refilled with blank cells that carry a programmable attribute. While the shift runs, a status bit reports busy and data-port accesses are held off through a ready output.

Top module: `vram_port`

## Requirements
- R1: Register 0 holds the low byte and register 1 holds the high byte of the 16-bit video pointer. Both read back what was last written, or where stepping has moved the pointer.
- R2: A write to register 2 stores the byte at the pointed location. A read of register 2 returns the byte stored at the pointed location.
- R3: With register 3 bit 0 set, each accepted access to register 2, read or write, adds one to the pointer.
- R4: With register 3 bit 0 clear, accesses to register 2 leave the pointer unchanged. Repeated reads return the same byte, and a read right after a write returns the written byte.
- R5: A step from pointer 0xFFFF gives 0x0000.
- R6: After reset, registers 0, 1, 3, 4, 5 and 7 read 0x00 and register 6 reads 0x07.
- R7: A write to register 7 with bit 0 set, while no shift is running, starts a screen shift. Registers 5:4 give the screen base address, and a row is 160 bytes. Every byte at base+160+k moves to base+k, for k below 3840. A write with bit 0 clear starts nothing.
- R8: At the end of a shift, the row at base+3840 is filled with 0x20 at even offsets and with the value of register 6 at odd offsets.
- R9: A read of register 7 shows bit 0 = 1 while a shift runs. An access to register 2 is held with ready low during a shift or while a prefetch is pending. Accesses to the other registers are never held.
- R10: After a shift ends, a read of register 2 returns the shifted content at the unchanged pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Bus access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register index 0 to 7 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| ready | output | 1 | Access completes at the next rising edge when high |

## Verification
The assertions assume a bus master that holds cs, we, reg_sel and wdata steady until ready is seen high, and that counts an access as done only on an edge where cs and ready are both high. The pointer-step and pointer-hold properties depend on this, because a held access must not move the pointer. The bench drives every input at the falling edge and keeps each request up until ready is high. The one exception is the stall probe during a shift, where the request is withdrawn before any edge sees it accepted.

// File: rtl/vram_pkg.sv
package vram_pkg;
   localparam logic [2:0] REG_PTR_LO = 3'd0;
   localparam logic [2:0] REG_PTR_HI = 3'd1;
   localparam logic [2:0] REG_DATA   = 3'd2;
   localparam logic [2:0] REG_CTRL   = 3'd3;
   localparam logic [2:0] REG_BASE_L = 3'd4;
   localparam logic [2:0] REG_BASE_H = 3'd5;
   localparam logic [2:0] REG_FILL   = 3'd6;
   localparam logic [2:0] REG_CMD    = 3'd7;

   localparam logic [7:0] BLANK_CHAR = 8'h20;
   localparam logic [7:0] FILL_RESET = 8'h07;

   typedef enum logic [1:0] {
      PF_VALID = 2'd0,
      PF_REQ   = 2'd1,
      PF_WAIT  = 2'd2
   } pf_state_t;

   typedef enum logic [1:0] {
      SC_IDLE = 2'd0,
      SC_RD   = 2'd1,
      SC_WR   = 2'd2,
      SC_CLR  = 2'd3
   } sc_state_t;
endpackage

// File: rtl/vram_mem.sv
module vram_mem #(
   parameter int MEM_AW        = 12,
   parameter int DATA_W        = 8,
   parameter bit WRITE_THROUGH = 1'b0
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [MEM_AW-1:0] addr,
   input  logic [DATA_W-1:0] wd,
   output logic [DATA_W-1:0] rd
);
   localparam int DEPTH = 1 << MEM_AW;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (en && we) store[addr] <= wd;
   end

   generate
      if (WRITE_THROUGH) begin : g_wt
         always_ff @(posedge clk) begin
            if (en) rd <= we ? wd : store[addr];
         end
      end else begin : g_rf
         always_ff @(posedge clk) begin
            if (en) rd <= store[addr];
         end
      end
   endgenerate
endmodule

// File: rtl/vram_cursor.sv
module vram_cursor
   import vram_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter bit HAS_AUTOINC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [7:0]        wdata,
   input  logic              data_rd,
   input  logic              data_wr,
   input  logic              autoinc,
   input  logic              port_free,
   input  logic              refetch,
   input  logic [7:0]        mem_rd,
   output logic [ADDR_W-1:0] ptr,
   output logic              rd_req,
   output logic [7:0]        pf_data,
   output logic              pf_valid
);
   localparam int HI_W = ADDR_W - 8;

   pf_state_t state_q;
   logic      step;

   generate
      if (HAS_AUTOINC) begin : g_step
         assign step = autoinc && (data_rd || data_wr);
      end else begin : g_nostep
         assign step = 1'b0;
      end
   endgenerate

   assign rd_req   = (state_q == PF_REQ) && port_free;
   assign pf_valid = (state_q == PF_VALID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (ld_lo) begin
         ptr[7:0] <= wdata;
      end else if (ld_hi) begin
         ptr[ADDR_W-1:8] <= wdata[HI_W-1:0];
      end else if (step) begin
         ptr <= ptr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PF_REQ;
         pf_data <= '0;
      end else begin
         if (data_wr && !step) pf_data <= wdata;
         else if (state_q == PF_WAIT) pf_data <= mem_rd;

         if (ld_lo || ld_hi || step || refetch) state_q <= PF_REQ;
         else if (rd_req) state_q <= PF_WAIT;
         else if (state_q == PF_WAIT) state_q <= PF_VALID;
      end
   end
endmodule

// File: rtl/vram_scroll.sv
module vram_scroll
   import vram_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int COLS       = 80,
   parameter int ROWS       = 25,
   parameter int CELL_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [7:0]        fill_attr,
   input  logic [7:0]        mem_rd,
   output logic              busy,
   output logic              done,
   output logic              m_en,
   output logic              m_we,
   output logic [ADDR_W-1:0] m_addr,
   output logic [7:0]        m_wd
);
   localparam int ROW_BYTES = COLS * CELL_BYTES;
   localparam int COPY_N    = ROW_BYTES * (ROWS - 1);
   localparam int CNT_W     = $clog2(COPY_N + 1);
   localparam logic [ADDR_W-1:0] ROW_OFF  = ADDR_W'(ROW_BYTES);
   localparam logic [ADDR_W-1:0] LAST_OFF = ADDR_W'(COPY_N);
   localparam logic [CNT_W-1:0]  COPY_END = CNT_W'(COPY_N - 1);
   localparam logic [CNT_W-1:0]  CLR_END  = CNT_W'(ROW_BYTES - 1);

   sc_state_t        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [ADDR_W-1:0] off;

   assign off  = ADDR_W'(cnt_q);
   assign busy = (state_q != SC_IDLE);
   assign done = (state_q == SC_CLR) && (cnt_q == CLR_END);

   always_comb begin
      m_en   = 1'b0;
      m_we   = 1'b0;
      m_addr = '0;
      m_wd   = '0;
      unique case (state_q)
         SC_RD: begin
            m_en   = 1'b1;
            m_addr = base + ROW_OFF + off;
         end
         SC_WR: begin
            m_en   = 1'b1;
            m_we   = 1'b1;
            m_addr = base + off;
            m_wd   = mem_rd;
         end
         SC_CLR: begin
            m_en   = 1'b1;
            m_we   = 1'b1;
            m_addr = base + LAST_OFF + off;
            m_wd   = cnt_q[0] ? fill_attr : BLANK_CHAR;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SC_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SC_IDLE: if (start) begin
               state_q <= SC_RD;
               cnt_q   <= '0;
            end
            SC_RD: state_q <= SC_WR;
            SC_WR: begin
               if (cnt_q == COPY_END) begin
                  state_q <= SC_CLR;
                  cnt_q   <= '0;
               end else begin
                  state_q <= SC_RD;
                  cnt_q   <= cnt_q + 1'b1;
               end
            end
            SC_CLR: begin
               if (cnt_q == CLR_END) begin
                  state_q <= SC_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= SC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vram_port.sv
module vram_port
   import vram_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int MEM_AW        = 12,
   parameter int COLS          = 80,
   parameter int ROWS          = 25,
   parameter bit HAS_AUTOINC   = 1'b1,
   parameter bit WRITE_THROUGH = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs,
   input  logic       we,
   input  logic [2:0] reg_sel,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       ready
);
   localparam int CELL_BYTES = 2;
   localparam int HI_W       = ADDR_W - 8;

   generate
      if (MEM_AW > ADDR_W) begin : g_bad_aw
         $error("MEM_AW must not exceed ADDR_W");
      end
      if (ADDR_W <= 8 || ADDR_W > 16) begin : g_bad_w
         $error("ADDR_W must lie in 9..16");
      end
      if (ROWS < 2 || COLS < 1) begin : g_bad_geom
         $error("screen needs at least two rows and one column");
      end
   endgenerate

   logic              autoinc;
   logic [ADDR_W-1:0] base_q;
   logic [7:0]        fill_q;
   logic              busy;
   logic              sc_done;
   logic              sc_en, sc_we;
   logic [ADDR_W-1:0] sc_addr;
   logic [7:0]        sc_wd;
   logic [ADDR_W-1:0] cur_addr;
   logic              cur_rd;
   logic [7:0]        pf_data;
   logic              pf_valid;
   logic [7:0]        mem_rd;
   logic              mem_en, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_wd;

   logic acc, data_sel, data_rd, data_wr, scroll_go;

   assign data_sel  = (reg_sel == REG_DATA);
   assign ready     = !(cs && data_sel && (busy || !pf_valid));
   assign acc       = cs && ready;
   assign data_rd   = acc && data_sel && !we;
   assign data_wr   = acc && data_sel && we;
   assign scroll_go = acc && we && (reg_sel == REG_CMD) && wdata[0] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         autoinc <= 1'b0;
         base_q  <= '0;
         fill_q  <= FILL_RESET;
      end else if (acc && we) begin
         unique case (reg_sel)
            REG_CTRL:   autoinc <= wdata[0];
            REG_BASE_L: base_q[7:0] <= wdata;
            REG_BASE_H: base_q[ADDR_W-1:8] <= wdata[HI_W-1:0];
            REG_FILL:   fill_q <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (reg_sel)
         REG_PTR_LO: rdata = cur_addr[7:0];
         REG_PTR_HI: rdata = 8'(cur_addr[ADDR_W-1:8]);
         REG_DATA:   rdata = pf_data;
         REG_CTRL:   rdata = {7'd0, autoinc};
         REG_BASE_L: rdata = base_q[7:0];
         REG_BASE_H: rdata = 8'(base_q[ADDR_W-1:8]);
         REG_FILL:   rdata = fill_q;
         default:    rdata = {7'd0, busy};
      endcase
   end

   assign mem_en   = busy ? sc_en   : (data_wr || cur_rd);
   assign mem_we   = busy ? sc_we   : data_wr;
   assign mem_addr = busy ? sc_addr : cur_addr;
   assign mem_wd   = busy ? sc_wd   : wdata;

   vram_cursor #(
      .ADDR_W      (ADDR_W),
      .HAS_AUTOINC (HAS_AUTOINC)
   ) u_cursor (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_lo     (acc && we && reg_sel == REG_PTR_LO),
      .ld_hi     (acc && we && reg_sel == REG_PTR_HI),
      .wdata     (wdata),
      .data_rd   (data_rd),
      .data_wr   (data_wr),
      .autoinc   (autoinc),
      .port_free (!busy),
      .refetch   (sc_done),
      .mem_rd    (mem_rd),
      .ptr       (cur_addr),
      .rd_req    (cur_rd),
      .pf_data   (pf_data),
      .pf_valid  (pf_valid)
   );

   vram_scroll #(
      .ADDR_W     (ADDR_W),
      .COLS       (COLS),
      .ROWS       (ROWS),
      .CELL_BYTES (CELL_BYTES)
   ) u_scroll (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (scroll_go),
      .base      (base_q),
      .fill_attr (fill_q),
      .mem_rd    (mem_rd),
      .busy      (busy),
      .done      (sc_done),
      .m_en      (sc_en),
      .m_we      (sc_we),
      .m_addr    (sc_addr),
      .m_wd      (sc_wd)
   );

   vram_mem #(
      .MEM_AW        (MEM_AW),
      .DATA_W        (8),
      .WRITE_THROUGH (WRITE_THROUGH)
   ) u_mem (
      .clk  (clk),
      .en   (mem_en),
      .we   (mem_we),
      .addr (mem_addr[MEM_AW-1:0]),
      .wd   (mem_wd),
      .rd   (mem_rd)
   );
endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs,
   input logic              we,
   input logic [2:0]        reg_sel,
   input logic [7:0]        wdata,
   input logic              ready,
   input logic              busy,
   input logic              autoinc,
   input logic [ADDR_W-1:0] cur_addr
);
   AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && reg_sel == 3'd2 && busy) |-> !ready); // R9

   AST_OTHER_REGS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && reg_sel != 3'd2) |-> ready); // R9

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && ready && reg_sel == 3'd2 && autoinc) |=> (cur_addr == $past(cur_addr) + 1'b1)); // R3

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && ready && reg_sel == 3'd2 && !autoinc) |=> $stable(cur_addr)); // R4

   AST_SHIFT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs && we && reg_sel == 3'd7 && wdata[0])); // R7
endmodule

bind vram_port vram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs       (cs),
   .we       (we),
   .reg_sel  (reg_sel),
   .wdata    (wdata),
   .ready    (ready),
   .busy     (busy),
   .autoinc  (autoinc),
   .cur_addr (cur_addr)
);

// File: tb/vram_port_test.sv
module vram_port_test;
   localparam int CLK_PERIOD = 10;
   localparam int BASE       = 16;
   localparam int ROW_B      = 160;
   localparam int SCREEN_B   = 4000;
   localparam int COPY_B     = 3840;
   localparam int NVEC       = 18;

   // {req[3:0], is_read, reg[2:0], data_or_expect[7:0]}
   localparam logic [15:0] VEC [NVEC] = '{
      {4'd3, 1'b0, 3'd3, 8'h01},
      {4'd1, 1'b0, 3'd0, 8'h34},
      {4'd1, 1'b0, 3'd1, 8'h02},
      {4'd2, 1'b0, 3'd2, 8'hAA},
      {4'd2, 1'b0, 3'd2, 8'hBB},
      {4'd2, 1'b0, 3'd2, 8'hCC},
      {4'd3, 1'b1, 3'd0, 8'h37},
      {4'd1, 1'b1, 3'd1, 8'h02},
      {4'd1, 1'b0, 3'd0, 8'h34},
      {4'd2, 1'b1, 3'd2, 8'hAA},
      {4'd3, 1'b1, 3'd2, 8'hBB},
      {4'd3, 1'b1, 3'd2, 8'hCC},
      {4'd4, 1'b0, 3'd3, 8'h00},
      {4'd4, 1'b0, 3'd0, 8'h35},
      {4'd4, 1'b1, 3'd2, 8'hBB},
      {4'd4, 1'b1, 3'd2, 8'hBB},
      {4'd4, 1'b0, 3'd2, 8'h5A},
      {4'd4, 1'b1, 3'd2, 8'h5A}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0;
   logic       we = 1'b0;
   logic [2:0] reg_sel = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       ready;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vram_port uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs      (cs),
      .we      (we),
      .reg_sel (reg_sel),
      .wdata   (wdata),
      .rdata   (rdata),
      .ready   (ready)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 29 + (a >> 5)) & 255);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [2:0] r, logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; we = 1'b1; reg_sel = r; wdata = d;
      #1;
      while (!ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      cs = 1'b0; we = 1'b0;
   endtask

   task automatic bus_rd(logic [2:0] r, output logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; we = 1'b0; reg_sel = r;
      #1;
      while (!ready) begin
         @(negedge clk);
         #1;
      end
      d = rdata;
      @(posedge clk);
      #1;
      cs = 1'b0;
   endtask

   task automatic summary();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      logic [7:0] v;
      int copy_err, clr_err, first_a, first_e, polls;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R6 reset values
      bus_rd(3'd0, v); check(v == 8'h00, "R6 ptr lo", v, 0);
      bus_rd(3'd1, v); check(v == 8'h00, "R6 ptr hi", v, 0);
      bus_rd(3'd3, v); check(v == 8'h00, "R6 ctrl", v, 0);
      bus_rd(3'd4, v); check(v == 8'h00, "R6 base lo", v, 0);
      bus_rd(3'd5, v); check(v == 8'h00, "R6 base hi", v, 0);
      bus_rd(3'd6, v); check(v == 8'h07, "R6 fill", v, 7);
      bus_rd(3'd7, v); check(v == 8'h00, "R6 status", v, 0);

      // vector table: R1 R2 R3 R4
      for (int i = 0; i < NVEC; i++) begin
         logic [3:0] rq;
         rq = VEC[i][15:12];
         if (VEC[i][11]) begin
            bus_rd(VEC[i][10:8], v);
            check(v == VEC[i][7:0], $sformatf("R%0d vector %0d", rq, i), v, VEC[i][7:0]);
         end else begin
            bus_wr(VEC[i][10:8], VEC[i][7:0]);
         end
      end

      // R5 wrap of the pointer
      bus_wr(3'd3, 8'h01);
      bus_wr(3'd0, 8'hFF);
      bus_wr(3'd1, 8'hFF);
      bus_wr(3'd2, 8'h77);
      bus_rd(3'd0, v); check(v == 8'h00, "R5 wrap lo", v, 0);
      bus_rd(3'd1, v); check(v == 8'h00, "R5 wrap hi", v, 0);
      bus_wr(3'd0, 8'hFF);
      bus_wr(3'd1, 8'hFF);
      bus_rd(3'd2, v); check(v == 8'h77, "R5 byte at top", v, 8'h77);

      // fill the screen area
      bus_wr(3'd4, 8'(BASE));
      bus_wr(3'd5, 8'h00);
      bus_wr(3'd6, 8'h1E);
      bus_wr(3'd0, 8'(BASE));
      bus_wr(3'd1, 8'h00);
      for (int a = BASE; a < BASE + SCREEN_B; a++) bus_wr(3'd2, pat(a));

      // R7 command with bit 0 clear starts nothing
      bus_wr(3'd7, 8'h00);
      bus_rd(3'd7, v); check(v == 8'h00, "R7 no start on bit0 clear", v, 0);

      bus_wr(3'd3, 8'h00);
      bus_wr(3'd0, 8'(BASE));
      bus_wr(3'd1, 8'h00);
      bus_rd(3'd2, v); check(v == pat(BASE), "R2 pre-shift byte", v, pat(BASE));

      // start the shift
      bus_wr(3'd7, 8'h01);
      bus_rd(3'd7, v); check(v == 8'h01, "R9 busy reads 1", v, 1);
      @(negedge clk);
      cs = 1'b1; we = 1'b0; reg_sel = 3'd2;
      #1;
      check(ready == 1'b0, "R9 data port held", ready, 0);
      cs = 1'b0;
      polls = 0;
      do begin
         bus_rd(3'd7, v);
         polls++;
      end while (v[0] && polls < 20000);
      check(v == 8'h00, "R9 busy clears", v, 0);

      // R10 refetch at unchanged pointer
      bus_rd(3'd2, v);
      check(v == pat(BASE + ROW_B), "R10 refetched byte", v, pat(BASE + ROW_B));

      // read back the screen
      bus_wr(3'd3, 8'h01);
      bus_wr(3'd0, 8'(BASE));
      bus_wr(3'd1, 8'h00);
      copy_err = 0; clr_err = 0; first_a = 0; first_e = 0;
      for (int o = 0; o < SCREEN_B; o++) begin
         logic [7:0] e;
         bus_rd(3'd2, v);
         if (o < COPY_B) e = pat(BASE + ROW_B + o);
         else e = o[0] ? 8'h1E : 8'h20;
         if (v != e) begin
            if (copy_err + clr_err == 0) begin first_a = v; first_e = e; end
            if (o < COPY_B) copy_err++; else clr_err++;
         end
      end
      check(copy_err == 0, "R7 rows moved up", first_a, first_e);
      check(clr_err == 0, "R8 last row blanked", first_a, first_e);

      finished = 1'b1;
      summary();
   end
endmodule